// File: doc/BRIEF.md
# Second-Operand Barrel Shifter

This block forms the second ALU operand and the shifter carry for a 32-bit integer datapath. It takes one of two sources. The first is a register value moved by one of five shift kinds, with the amount taken either from a 5-bit constant or from the low byte of another register. The second is a 12-bit immediate that holds an 8-bit value and a 4-bit rotate field; the value is rotated right by twice that field. The incoming C flag feeds rotate-through-carry and the cases where the carry stays unchanged.

Each request is one transfer on a valid/ready input. The result, an operand and a carry, leaves one cycle later on a valid/ready output. The block has a single output register. It accepts a new request when that register is empty or is being drained in the same cycle (`in_ready = !out_valid || out_ready`). While the consumer holds `out_ready` low, the stored result stays unchanged and new requests are refused. No request is dropped or duplicated.

Top module: `operand_shifter`

## Requirements
- R1: Shift kind code 0 is a logical left shift. For amounts 1 to 31 the operand is `reg_val << n` and the carry is bit `32-n` of `reg_val`.
- R2: Shift kind code 1 is a logical right shift. For amounts 1 to 31 the operand is `reg_val >> n` with zero fill and the carry is bit `n-1` of `reg_val`.
- R3: Shift kind code 2 is an arithmetic right shift. For amounts 1 to 31 the vacated bits take `reg_val[31]` and the carry is bit `n-1`. For amounts of 32 or more every bit and the carry equal `reg_val[31]`.
- R4: Shift kind code 3 rotates right by the amount modulo 32. For any nonzero amount the carry equals bit 31 of the result, so a nonzero multiple of 32 returns `reg_val` with carry `reg_val[31]`.
- R5: For kind codes 0 to 3 an amount of zero returns `reg_val` unchanged and the carry equals `c_in`.
- R6: Shift kind code 4 rotates right by one through the carry: the operand is `{c_in, reg_val[31:1]}` and the carry is `reg_val[0]`. The amount inputs have no effect.
- R7: When `amt_from_reg` is 1, the amount is `amt_reg[7:0]` and bits 31:8 have no effect. When it is 0, the amount is `amt_imm`. A logical shift (code 0 or 1) by exactly 32 gives 0 with carry `reg_val[0]` for code 0 and `reg_val[31]` for code 1. Amounts above 32 give 0 with carry 0.
- R8: When `use_imm` is 1, the operand is the zero-extended `imm12[7:0]` rotated right by `2*imm12[11:8]`, and the register and shift inputs have no effect.
- R9: When `use_imm` is 1, the carry is `c_in` if `imm12[11:8]` is 0. Otherwise it is bit 31 of the rotated operand.
- R10: A request is taken on a rising edge with `in_valid && in_ready`. Its result shows on the next cycle with `out_valid` high. `in_ready` equals `!out_valid || out_ready`.
- R11: While `out_valid` is high and `out_ready` is low, `out_operand` and `out_carry` hold their values and no new request is taken.
- R12: Unused kind codes 5 to 7 return `reg_val` unchanged with carry `c_in`.
- R13: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request is present |
| in_ready | output | 1 | Block can take a request this cycle |
| use_imm | input | 1 | 1: rotated immediate source, 0: shifted register source |
| shift_kind | input | 3 | 0 LSL, 1 LSR, 2 ASR, 3 ROR, 4 RRX, 5-7 pass |
| amt_from_reg | input | 1 | 1: amount from `amt_reg[7:0]`, 0: from `amt_imm` |
| amt_imm | input | 5 | Constant shift amount |
| amt_reg | input | 32 | Register holding the shift amount |
| reg_val | input | 32 | Register value to be shifted |
| imm12 | input | 12 | Rotate field in bits 11:8, value in bits 7:0 |
| c_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_operand | output | 32 | Second operand |
| out_carry | output | 1 | Shifter carry-out |

## Verification
Every result is due exactly one rising edge after its request is taken, because the only register on the path is the output stage. The bench drives a request at a falling edge and checks the operand, the carry and `out_valid` at the next falling edge, halfway between the taking edge and the following one. While `out_ready` is low, the stalled result is checked at each falling edge to confirm it stays unchanged, and `in_ready` is checked to stay low. The request held back during the stall is checked at the first falling edge after `out_ready` returns high.

// File: rtl/opsh_pkg.sv
`timescale 1ns/1ps
package opsh_pkg;
  typedef enum logic [2:0] {
    SK_LSL = 3'd0,
    SK_LSR = 3'd1,
    SK_ASR = 3'd2,
    SK_ROR = 3'd3,
    SK_RRX = 3'd4
  } shift_kind_e;

  localparam int unsigned KIND_W = 3;
endpackage

// File: rtl/opsh_reg_shift.sv
`timescale 1ns/1ps
module opsh_reg_shift #(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = 8
) (
  input  logic [W-1:0]                 val,
  input  logic [opsh_pkg::KIND_W-1:0]  kind,
  input  logic [AW-1:0]                amt,
  input  logic                         cin,
  output logic [W-1:0]                 res,
  output logic                         cout
);
  import opsh_pkg::*;

  localparam int unsigned RW = $clog2(W);
  localparam logic [AW-1:0] FULL = AW'(W);

  logic [W:0]          lwide;
  logic [W:0]          rwide;
  logic signed [W:0]   awide;
  logic [AW-1:0]       asr_amt;
  logic [RW-1:0]       rot;
  logic [2*W-1:0]      rwrap;
  logic                amt_zero;

  // left shift keeps the last bit out in position W
  assign lwide    = {1'b0, val} << amt;
  // right shifts keep the last bit out in position 0
  assign rwide    = {val, 1'b0} >> amt;
  assign asr_amt  = (amt > FULL) ? FULL : amt;
  assign awide    = $signed({val, 1'b0}) >>> asr_amt;
  assign rot      = amt[RW-1:0];
  assign rwrap    = {val, val} >> rot;
  assign amt_zero = (amt == '0);

  always_comb begin
    res  = val;
    cout = cin;
    unique case (kind)
      SK_LSL: if (!amt_zero) begin res = lwide[W-1:0]; cout = lwide[W]; end
      SK_LSR: if (!amt_zero) begin res = rwide[W:1];   cout = rwide[0]; end
      SK_ASR: if (!amt_zero) begin res = awide[W:1];   cout = awide[0]; end
      SK_ROR: if (!amt_zero) begin res = rwrap[W-1:0]; cout = rwrap[W-1]; end
      SK_RRX: begin res = {cin, val[W-1:1]}; cout = val[0]; end
      default: begin res = val; cout = cin; end
    endcase
  end
endmodule

// File: rtl/opsh_imm_rot.sv
`timescale 1ns/1ps
module opsh_imm_rot #(
  parameter int unsigned W     = 32,
  parameter int unsigned IMM_W = 8,
  parameter int unsigned ROT_W = 4
) (
  input  logic [IMM_W+ROT_W-1:0] field,
  input  logic                   cin,
  output logic [W-1:0]           res,
  output logic                   cout
);
  localparam int unsigned RW = $clog2(W);

  logic [ROT_W-1:0] rot_f;
  logic [RW-1:0]    ramt;
  logic [W-1:0]     base;
  logic [2*W-1:0]   wrap;

  assign rot_f = field[IMM_W+ROT_W-1:IMM_W];
  assign ramt  = RW'({rot_f, 1'b0});
  assign base  = W'(field[IMM_W-1:0]);
  assign wrap  = {base, base} >> ramt;
  assign res   = wrap[W-1:0];
  assign cout  = (rot_f == '0) ? cin : wrap[W-1];
endmodule

// File: rtl/opsh_out_stage.sv
`timescale 1ns/1ps
module opsh_out_stage #(
  parameter int unsigned DW = 33
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  // R10: a taken request always shows up on the next cycle
  a_r10_fill: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && (out_data == $past(in_data)));

  // R11: a stalled result neither changes nor disappears
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

// File: rtl/operand_shifter.sv
`timescale 1ns/1ps
module operand_shifter #(
  parameter int unsigned W      = 32,
  parameter int unsigned AW     = 8,
  parameter int unsigned IAW    = 5,
  parameter int unsigned IMM_W  = 8,
  parameter int unsigned ROT_W  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic                         use_imm,
  input  logic [opsh_pkg::KIND_W-1:0]  shift_kind,
  input  logic                         amt_from_reg,
  input  logic [IAW-1:0]               amt_imm,
  input  logic [W-1:0]                 amt_reg,
  input  logic [W-1:0]                 reg_val,
  input  logic [IMM_W+ROT_W-1:0]       imm12,
  input  logic                         c_in,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [W-1:0]                 out_operand,
  output logic                         out_carry
);
  import opsh_pkg::*;

  localparam int unsigned DW = W + 1;

  logic [AW-1:0] amt_sel;
  logic [W-1:0]  sh_res, im_res;
  logic          sh_c, im_c;
  logic [DW-1:0] nxt, held;
  logic          accept;

  assign amt_sel = amt_from_reg ? amt_reg[AW-1:0] : AW'(amt_imm);

  opsh_reg_shift #(.W(W), .AW(AW)) u_shift (
    .val(reg_val), .kind(shift_kind), .amt(amt_sel), .cin(c_in),
    .res(sh_res), .cout(sh_c)
  );

  opsh_imm_rot #(.W(W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_imm (
    .field(imm12), .cin(c_in), .res(im_res), .cout(im_c)
  );

  assign nxt = use_imm ? {im_res, im_c} : {sh_res, sh_c};

  opsh_out_stage #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(nxt),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(held)
  );

  assign out_operand = held[DW-1:1];
  assign out_carry   = held[0];
  assign accept      = in_valid && in_ready;

  // R6: rotate through carry, checked from ports across the stage
  a_r6_rrx: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !use_imm && shift_kind == SK_RRX |=>
      out_operand[W-1] == $past(c_in) && out_carry == $past(reg_val[0]));

  // R5: zero amount leaves value and carry untouched
  a_r5_zero_amount: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !use_imm && shift_kind <= SK_ROR && amt_sel == '0 |=>
      out_operand == $past(reg_val) && out_carry == $past(c_in));

  // R9: unrotated immediate keeps the incoming carry
  a_r9_imm_carry: assert property (@(posedge clk) disable iff (!rst_n)
    accept && use_imm && imm12[IMM_W+ROT_W-1:IMM_W] == '0 |=>
      out_carry == $past(c_in) && out_operand == W'($past(imm12[IMM_W-1:0])));

  // R4: a nonzero rotate always copies result bit 31 into the carry
  a_r4_ror_carry: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !use_imm && shift_kind == SK_ROR && amt_sel != '0 |=>
      out_carry == out_operand[W-1]);
endmodule

// File: tb/tb_operand_shifter.sv
`timescale 1ns/1ps
module tb_operand_shifter;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic        use_imm = 1'b0;
  logic [2:0]  shift_kind = '0;
  logic        amt_from_reg = 1'b0;
  logic [4:0]  amt_imm = '0;
  logic [31:0] amt_reg = '0, reg_val = '0;
  logic [11:0] imm12 = '0;
  logic        c_in = 1'b0;
  logic        out_valid, out_ready = 1'b1;
  logic [31:0] out_operand;
  logic        out_carry;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  operand_shifter dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .use_imm(use_imm), .shift_kind(shift_kind), .amt_from_reg(amt_from_reg),
    .amt_imm(amt_imm), .amt_reg(amt_reg), .reg_val(reg_val), .imm12(imm12),
    .c_in(c_in), .out_valid(out_valid), .out_ready(out_ready),
    .out_operand(out_operand), .out_carry(out_carry)
  );

  // bit-at-a-time model of the shift rules
  function automatic logic [32:0] ref_shift(logic [2:0] k, logic [7:0] n,
                                            logic [31:0] v, logic c);
    if (k == 3'd4) return {c, v[31:1], v[0]};
    if (k > 3'd4 || n == 0) return {v, c};
    for (int i = 0; i < int'(n); i++) begin
      case (k)
        3'd0: begin c = v[31]; v = {v[30:0], 1'b0}; end
        3'd1: begin c = v[0];  v = {1'b0, v[31:1]}; end
        3'd2: begin c = v[0];  v = {v[31], v[31:1]}; end
        default: begin c = v[0]; v = {v[0], v[31:1]}; end
      endcase
    end
    return {v, c};
  endfunction

  function automatic logic [32:0] ref_imm(logic [11:0] f, logic c);
    logic [31:0] v = {24'b0, f[7:0]};
    for (int i = 0; i < 2 * int'(f[11:8]); i++) v = {v[0], v[31:1]};
    return {v, (f[11:8] == 0) ? c : v[31]};
  endfunction

  task automatic chk(string req, logic [32:0] act, logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h/%b expected %h/%b", req,
               act[32:1], act[0], exp[32:1], exp[0]);
    end
  endtask

  task automatic chk1(string req, logic act, logic exp);
    chk(req, {32'b0, act}, {32'b0, exp});
  endtask

  task automatic drive(logic ui, logic [2:0] k, logic fr, logic [4:0] ai,
                       logic [31:0] ar, logic [31:0] v, logic [11:0] im, logic c);
    use_imm = ui; shift_kind = k; amt_from_reg = fr; amt_imm = ai;
    amt_reg = ar; reg_val = v; imm12 = im; c_in = c;
  endtask

  function automatic logic [32:0] expect_now();
    logic [7:0] n = amt_from_reg ? amt_reg[7:0] : {3'b0, amt_imm};
    return use_imm ? ref_imm(imm12, c_in) : ref_shift(shift_kind, n, reg_val, c_in);
  endfunction

  // one request, result checked one edge later at the falling edge
  task automatic run(string req, logic ui, logic [2:0] k, logic fr, logic [4:0] ai,
                     logic [31:0] ar, logic [31:0] v, logic [11:0] im, logic c);
    logic [32:0] e;
    @(negedge clk);
    drive(ui, k, fr, ai, ar, v, im, c);
    e = expect_now();
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk1({req, " R10 valid"}, out_valid, 1'b1);
    chk(req, {out_operand, out_carry}, e);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [32:0] ea, eb;
    void'($urandom(32'd20240611));
    #(CLK_P * 3 + 3ns);
    chk1("R13 out_valid in reset", out_valid, 1'b0);
    chk1("R13 in_ready in reset", in_ready, 1'b1);
    @(negedge clk); rst_n = 1'b1;

    // directed corners
    run("R1 lsl 4",    0, 3'd0, 0, 5'd4,  0, 32'hF000_0001, 0, 0);
    run("R1 lsl 31",   0, 3'd0, 0, 5'd31, 0, 32'h0000_0003, 0, 0);
    run("R2 lsr 1",    0, 3'd1, 0, 5'd1,  0, 32'h8000_0001, 0, 0);
    run("R2 lsr 31",   0, 3'd1, 0, 5'd31, 0, 32'hC000_0000, 0, 1);
    run("R3 asr 8 neg",0, 3'd2, 0, 5'd8,  0, 32'h8000_0180, 0, 0);
    run("R3 asr 40",   0, 3'd2, 1, 5'd0,  32'd40, 32'h9000_0000, 0, 0);
    run("R3 asr 32 pos",0,3'd2, 1, 5'd0,  32'd32, 32'h7FFF_FFFF, 0, 1);
    run("R4 ror 8",    0, 3'd3, 0, 5'd8,  0, 32'h1234_5680, 0, 0);
    run("R4 ror 64",   0, 3'd3, 1, 5'd0,  32'd64, 32'h8765_4321, 0, 0);
    run("R5 zero lsl", 0, 3'd0, 0, 5'd0,  0, 32'hDEAD_BEEF, 0, 1);
    run("R5 zero reg asr",0,3'd2,1, 5'd0, 32'hFFFF_FF00, 32'h8000_0001, 0, 0);
    run("R6 rrx c1",   0, 3'd4, 0, 5'd9,  0, 32'h0000_0003, 0, 1);
    run("R6 rrx c0",   0, 3'd4, 1, 5'd0,  32'd7, 32'h8000_0000, 0, 0);
    run("R7 lsl 32",   0, 3'd0, 1, 5'd0,  32'd32, 32'h0000_0001, 0, 0);
    run("R7 lsr 32",   0, 3'd1, 1, 5'd0,  32'd32, 32'h8000_0000, 0, 0);
    run("R7 lsl 33",   0, 3'd0, 1, 5'd0,  32'd33, 32'hFFFF_FFFF, 0, 1);
    run("R7 lsr 255",  0, 3'd1, 1, 5'd0,  32'd255, 32'hFFFF_FFFF, 0, 1);
    run("R7 high bits",0, 3'd1, 1, 5'd0,  32'hABCD_0004, 32'hFFFF_0000, 0, 0);
    run("R8 imm rot 13",1,3'd0, 0, 5'd3,  0, 32'h1111_1111, 12'hDFF, 0);
    run("R8 imm rot 1",1, 3'd2, 0, 5'd3,  0, 0, 12'h13F, 0);
    run("R9 imm rot 0",1, 3'd0, 0, 5'd3,  0, 0, 12'h0AB, 1);
    run("R9 imm b31 0",1, 3'd0, 0, 5'd3,  0, 0, 12'h170, 1);
    run("R12 code 5",  0, 3'd5, 0, 5'd7,  0, 32'h0F0F_0F0F, 0, 1);
    run("R12 code 7",  0, 3'd7, 1, 5'd0,  32'd3, 32'h1234_5678, 0, 0);

    // back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    drive(0, 3'd0, 0, 5'd3, 0, 32'h0000_00F1, 0, 0);
    ea = expect_now();
    in_valid = 1'b1;
    @(negedge clk);
    drive(1, 3'd0, 0, 5'd0, 0, 0, 12'h2C3, 1);
    eb = expect_now();
    chk1("R10 in_ready low when full", in_ready, 1'b0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk1("R11 stalled valid", out_valid, 1'b1);
      chk("R11 stalled data", {out_operand, out_carry}, ea);
      chk1("R11 in_ready stays low", in_ready, 1'b0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 held request after release", {out_operand, out_carry}, eb);
    @(negedge clk);
    chk1("R10 drained", out_valid, 1'b0);

    // constrained random
    for (int t = 0; t < 400; t++) begin
      logic [31:0] ar;
      logic [2:0]  k;
      ar = $urandom();
      case ($urandom_range(0, 5))
        0: ar[7:0] = 8'd0;
        1: ar[7:0] = 8'd32;
        2: ar[7:0] = 8'd33;
        3: ar[7:0] = 8'(31 + $urandom_range(0, 2));
        default: ;
      endcase
      k = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(5, 7)) : 3'($urandom_range(0, 4));
      run(use_imm_pick() ? "R8 R9 random imm" : "R1 R2 R3 R4 R6 R7 random shift",
          last_ui, k, 1'($urandom()), 5'($urandom()), ar, $urandom(),
          12'($urandom()), 1'($urandom()));
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  logic last_ui = 1'b0;
  function automatic bit use_imm_pick();
    last_ui = ($urandom_range(0, 3) == 0);
    return last_ui;
  endfunction
endmodule